// File: doc/BRIEF.md
# Interrupt Cause and Mask Unit

This block collects completion events from a small Ethernet DMA controller and turns them into one level-sensitive interrupt line. Single-cycle pulses from the receive path and from two transmit queues set sticky bits in a 32-bit cause register. A 32-bit mask register selects which of those bits may reach the interrupt output. The output stays high for as long as any cause bit is set under a set mask bit.

Software reaches both registers over a simple 32-bit register bus with combinational reads. A write to the cause register is ANDed into it, so a driver clears the bits it has serviced by writing zeros to them and ones everywhere else. A write to the mask register replaces its contents. A hardware event has priority over a software clear that hits the same bit in the same cycle, so no event is lost.

Top module: `irq_cause_mask_unit`

## Requirements
- R1: While reset is asserted and after it is released, the cause register and the mask register both read zero and irq_o is low.
- R2: The cause register is at offset 0x450 and the mask register at offset 0x458. Both are 32 bits wide, and a read of either returns its stored value.
- R3: A write to offset 0x450 sets cause to cause AND wdata. Bits written as 0 clear and bits written as 1 are kept. A write can never set a cause bit.
- R4: A pulse on rx_done_i sets cause bit 0 on the next clock edge.
- R5: A pulse on tx_done_i[q] sets cause bit 3−q. Queue 0 sets bit 3 and queue 1 sets bit 2, and both can be set in the same cycle.
- R6: irq_o is high exactly when (cause AND mask) is nonzero. This includes the cycle right after a mask write that exposes a pending cause bit.
- R7: If an event and a software clear hit the same cause bit in the same cycle, the bit ends up set.
- R8: A read of any offset other than 0x450 and 0x458 returns zero. A write to any other offset changes neither register.
- R9: A write to offset 0x458 stores all 32 bits of wdata in the mask register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe, one write per cycle |
| bus_addr_i | input | 12 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from bus_addr_i |
| rx_done_i | input | 1 | Receive-complete event pulse |
| tx_done_i | input | 2 | Transmit-done event pulse, one bit per queue |
| irq_o | output | 1 | Level interrupt request |

## Verification
On every cycle, the assertions check four things. No cause bit rises unless an event pulsed in the previous cycle. Every pulsed event leaves its bit set, even when a clear lands on it at the same time. The mask holds its value when it is not written. An unmapped address reads zero. The bench scenarios cover the behaviour that needs a reference value:
- the exact bit that each event source sets, checked against the queue-index rule;
- the AND semantics of cause writes;
- the full-width mask store;
- the interrupt level across masking and unmasking;
- reset in the middle of operation.

// File: rtl/icm_pkg.sv
package icm_pkg;
  localparam int unsigned ICM_DATA_W  = 32;
  localparam int unsigned ICM_ADDR_W  = 12;
  localparam int unsigned ICM_NUM_TXQ = 2;
  localparam logic [ICM_ADDR_W-1:0] ICM_CAUSE_OFS = 12'h450;
  localparam logic [ICM_ADDR_W-1:0] ICM_MASK_OFS  = 12'h458;
  localparam int unsigned ICM_RX_BIT     = 0;
  localparam int unsigned ICM_TX_TOP_BIT = 3;  // queue q -> bit TOP-q

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_CAUSE = 2'd1,
    SEL_MASK  = 2'd2
  } icm_sel_e;
endpackage

// File: rtl/icm_decode.sv
module icm_decode
  import icm_pkg::*;
#(
  parameter int unsigned DATA_W = ICM_DATA_W,
  parameter int unsigned ADDR_W = ICM_ADDR_W,
  parameter logic [ADDR_W-1:0] CAUSE_OFS = ICM_CAUSE_OFS,
  parameter logic [ADDR_W-1:0] MASK_OFS  = ICM_MASK_OFS
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] cause_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic              cause_we_o,
  output logic              mask_we_o,
  output logic [DATA_W-1:0] rdata_o
);
  icm_sel_e sel;

  always_comb begin
    if (addr_i == CAUSE_OFS)      sel = SEL_CAUSE;
    else if (addr_i == MASK_OFS)  sel = SEL_MASK;
    else                          sel = SEL_NONE;
  end

  assign cause_we_o = we_i && (sel == SEL_CAUSE);
  assign mask_we_o  = we_i && (sel == SEL_MASK);

  always_comb begin
    unique case (sel)
      SEL_CAUSE: rdata_o = cause_i;
      SEL_MASK:  rdata_o = mask_i;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/icm_cause_reg.sv
module icm_cause_reg
  import icm_pkg::*;
#(
  parameter int unsigned DATA_W     = ICM_DATA_W,
  parameter int unsigned NUM_TXQ    = ICM_NUM_TXQ,
  parameter int unsigned RX_BIT     = ICM_RX_BIT,
  parameter int unsigned TX_TOP_BIT = ICM_TX_TOP_BIT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               rx_i,
  input  logic [NUM_TXQ-1:0] tx_i,
  output logic [DATA_W-1:0]  cause_o
);
  localparam int unsigned LOW_TX_BIT = TX_TOP_BIT - (NUM_TXQ - 1);

  logic [DATA_W-1:0] set_vec;
  logic [DATA_W-1:0] cause_q;
  logic [DATA_W-1:0] kept;

  // events map to fixed bit positions; tx queues count down from TX_TOP_BIT
  always_comb begin
    set_vec = '0;
    set_vec[RX_BIT] = rx_i;
    for (int q = 0; q < NUM_TXQ; q++) begin
      set_vec[TX_TOP_BIT-q] = set_vec[TX_TOP_BIT-q] | tx_i[q];
    end
  end

  assign kept = we_i ? (cause_q & wdata_i) : cause_q;

  // event set is ORed after the clear so it wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= kept | set_vec;
  end

  assign cause_o = cause_q;

  generate
    if (LOW_TX_BIT > TX_TOP_BIT || TX_TOP_BIT >= DATA_W) begin : g_bad_map
      initial $error("tx bit map out of range");
    end
  endgenerate

  // R3: software can never set a bit; only a prior event can
  a_r3_no_sw_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_q & ~$past(cause_q) & ~$past(set_vec)) == '0);

  // R7: every pulsed event is present after the edge, clear or not
  a_r7_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_q & $past(set_vec)) == $past(set_vec));
endmodule

// File: rtl/icm_mask_reg.sv
module icm_mask_reg
  import icm_pkg::*;
#(
  parameter int unsigned DATA_W = ICM_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mask_o
);
  logic [DATA_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '0;
    else if (we_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;

  // R9: mask only changes on its own write strobe
  a_r9_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(we_i) |-> $stable(mask_q));
endmodule

// File: rtl/irq_cause_mask_unit.sv
module irq_cause_mask_unit
  import icm_pkg::*;
#(
  parameter int unsigned DATA_W     = ICM_DATA_W,
  parameter int unsigned ADDR_W     = ICM_ADDR_W,
  parameter int unsigned NUM_TXQ    = ICM_NUM_TXQ,
  parameter logic [ADDR_W-1:0] CAUSE_OFS = ICM_CAUSE_OFS,
  parameter logic [ADDR_W-1:0] MASK_OFS  = ICM_MASK_OFS,
  parameter int unsigned RX_BIT     = ICM_RX_BIT,
  parameter int unsigned TX_TOP_BIT = ICM_TX_TOP_BIT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  input  logic               rx_done_i,
  input  logic [NUM_TXQ-1:0] tx_done_i,
  output logic               irq_o
);
  logic [DATA_W-1:0] cause;
  logic [DATA_W-1:0] mask;
  logic              cause_we;
  logic              mask_we;

  icm_decode #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .CAUSE_OFS(CAUSE_OFS), .MASK_OFS(MASK_OFS)
  ) u_decode (
    .we_i(bus_we_i), .addr_i(bus_addr_i),
    .cause_i(cause), .mask_i(mask),
    .cause_we_o(cause_we), .mask_we_o(mask_we),
    .rdata_o(bus_rdata_o)
  );

  icm_cause_reg #(
    .DATA_W(DATA_W), .NUM_TXQ(NUM_TXQ),
    .RX_BIT(RX_BIT), .TX_TOP_BIT(TX_TOP_BIT)
  ) u_cause (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(cause_we), .wdata_i(bus_wdata_i),
    .rx_i(rx_done_i), .tx_i(tx_done_i),
    .cause_o(cause)
  );

  icm_mask_reg #(.DATA_W(DATA_W)) u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(mask_we), .wdata_i(bus_wdata_i),
    .mask_o(mask)
  );

  assign irq_o = |(cause & mask);

  // R6: interrupt implies something pending and something enabled
  a_r6_irq_needs_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cause != '0) && (mask != '0));

  // R8: unmapped offsets read as zero
  a_r8_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i != CAUSE_OFS && bus_addr_i != MASK_OFS) |-> bus_rdata_o == '0);

  // R8: a write strobe reaches at most one register
  a_r8_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cause_we, mask_we}));
endmodule

// File: tb/tb_irq_cause_mask_unit.sv
module tb_irq_cause_mask_unit;
  localparam logic [11:0] A_CAUSE = 12'h450;
  localparam logic [11:0] A_MASK  = 12'h458;

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic        rx;
    logic [1:0]  tx;
    logic [31:0] exp_cause;
    logic [31:0] exp_mask;
    logic        exp_irq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h000, 32'h0,         1'b1, 2'b00, 32'h1, 32'h0,         1'b0}, // R4
    '{1'b0, 12'h000, 32'h0,         1'b0, 2'b01, 32'h9, 32'h0,         1'b0}, // R5 q0
    '{1'b0, 12'h000, 32'h0,         1'b0, 2'b10, 32'hD, 32'h0,         1'b0}, // R5 q1
    '{1'b1, A_MASK,  32'h4,         1'b0, 2'b00, 32'hD, 32'h4,         1'b1}, // R6
    '{1'b1, A_CAUSE, 32'hFFFFFFFB,  1'b0, 2'b00, 32'h9, 32'h4,         1'b0}, // R3 clear
    '{1'b1, A_CAUSE, 32'hFFFFFFFF,  1'b0, 2'b00, 32'h9, 32'h4,         1'b0}, // R3 no set
    '{1'b1, A_MASK,  32'hFFFFFFFF,  1'b0, 2'b00, 32'h9, 32'hFFFFFFFF,  1'b1}, // R9
    '{1'b1, A_CAUSE, 32'h0,         1'b1, 2'b00, 32'h1, 32'hFFFFFFFF,  1'b1}, // R7 rx
    '{1'b1, A_CAUSE, 32'h0,         1'b0, 2'b11, 32'hC, 32'hFFFFFFFF,  1'b1}, // R7 tx
    '{1'b1, 12'h454, 32'h0,         1'b0, 2'b00, 32'hC, 32'hFFFFFFFF,  1'b1}, // R8
    '{1'b1, A_CAUSE, 32'h0,         1'b0, 2'b00, 32'h0, 32'hFFFFFFFF,  1'b0}, // R3
    '{1'b1, A_MASK,  32'hA5A50000,  1'b0, 2'b00, 32'h0, 32'hA5A50000,  1'b0}, // R9
    '{1'b0, 12'h000, 32'h0,         1'b1, 2'b00, 32'h1, 32'hA5A50000,  1'b0}, // R6 masked
    '{1'b0, 12'h000, 32'h0,         1'b0, 2'b01, 32'h9, 32'hA5A50000,  1'b0}, // R6 masked
    '{1'b1, A_MASK,  32'h8,         1'b0, 2'b00, 32'h9, 32'h8,         1'b1}  // R6 unmask
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rx = 1'b0;
  logic [1:0]  tx = '0;
  logic        irq;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_cause_mask_unit dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .rx_done_i(rx), .tx_done_i(tx), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic check_state(input string req, input logic [31:0] ec,
                             input logic [31:0] em, input logic ei);
    logic [31:0] d;
    we = 1'b0;
    rd(A_CAUSE, d); chk({req, " cause"}, d, ec);
    rd(A_MASK, d);  chk({req, " mask"}, d, em);
    chk({req, " irq"}, {31'b0, irq}, {31'b0, ei});
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    check_state("R1 in-reset", 32'h0, 32'h0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 post-reset", 32'h0, 32'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      we = VECS[i].we; addr = VECS[i].addr; wdata = VECS[i].wdata;
      rx = VECS[i].rx; tx = VECS[i].tx;
      @(negedge clk);
      rx = 1'b0; tx = '0;
      check_state($sformatf("R2/vec%0d", i), VECS[i].exp_cause, VECS[i].exp_mask, VECS[i].exp_irq);
    end

    // R8: unmapped reads return zero while both registers are nonzero
    rd(12'h454, d); chk("R8 read 0x454", d, 32'h0);
    rd(12'h000, d); chk("R8 read 0x000", d, 32'h0);
    rd(12'h44C, d); chk("R8 read 0x44C", d, 32'h0);
    rd(12'hC50, d); chk("R8 read 0xC50", d, 32'h0);

    // R8: write to near-miss offset of mask leaves mask intact
    @(negedge clk);
    we = 1'b1; addr = 12'h45C; wdata = 32'h0;
    @(negedge clk);
    check_state("R8 write 0x45C", 32'h9, 32'h8, 1'b1);

    // R5: both queues in one cycle after full clear
    @(negedge clk);
    we = 1'b1; addr = A_CAUSE; wdata = 32'h0;
    @(negedge clk);
    we = 1'b0; tx = 2'b11;
    @(negedge clk);
    tx = '0;
    check_state("R5 both queues", 32'hC, 32'h8, 1'b1);

    // R1: reset mid-run clears everything
    rst_n = 1'b0;
    #1;
    check_state("R1 mid-run reset", 32'h0, 32'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 after re-release", 32'h0, 32'h0, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule